// File: doc/BRIEF.md
# Storage Host Adapter Register File with Interrupt Merge

This block is the memory-mapped register space of a multi-port storage host adapter. A simple register bus (valid, write, word address, 32-bit data) reaches a small global region and an array of per-port windows. The global region reports the adapter's fixed capabilities, holds the interrupt-enable control and the adapter-reset trigger, and shows which ports have an unmasked interrupt pending. Each port window holds the base addresses used by the data movers, the port interrupt status and mask, the command/status word, the command-issue vector, the link status/control/error/active words, the task-file shadow and the device signature.

Per-port interrupt status bits are set by one-cycle event pulses from the transport logic and cleared by software writing ones. Each port's status ANDed with its mask folds into one bit of a global pending vector, and the single interrupt line is raised only when that vector is nonzero and global interrupts are enabled. A detect-field transition in the link control register performs a port reset; a reset-bit write to global control resets the whole adapter.

Top module: `hba_regfile`

## Requirements
- R1: Global region is offsets 0x000-0x0FF; port p's 128-byte window starts at 0x100 + p*0x80. Addresses at or above 0x100 + NUM_PORTS*0x80 read 0 and ignore writes, and a write whose address bits [1:0] are not zero is ignored.
- R2: After reset: global control reads 0x80000000, port command word reads 0x00000006 (spin-up bit 1, power-on bit 2), interrupt status, mask and command-issue read 0, task-file word (offset 0x20) reads 0x7F, signature (offset 0x24) reads 0x00000101 with a drive attached and 0xFFFFFFFF without, and the interrupt line is low.
- R3: Global interrupt status (offset 0x08) bit p is 1 exactly when port p's status AND mask is nonzero, visible two cycles after the change; writing ones there cannot clear a bit whose port source is still pending.
- R4: irq_out is high only while the global pending vector is nonzero and global control bit 1 (interrupt enable) is set.
- R5: Port interrupt status (offset 0x10) bits are set by port_evt pulses and cleared by writing 1 to them; an event and a clear on the same bit in the same cycle leaves the bit set.
- R6: Port interrupt mask (offset 0x14) stores only the bits in 0xFDC000FF.
- R7: A port command write (offset 0x18) stores the value with bits 15 (list running) and 14 (receive running) removed, then sets bit 15 if bit 0 (start) is set and bit 14 if bit 4 (receive enable) is set.
- R8: Command-issue writes (offset 0x38) OR the value into the register; writing zeros clears nothing.
- R9: A global control write (offset 0x04) with bit 0 set resets every register to its reset value; otherwise global control becomes bits 1:0 of the value (bit 0 reads 0) ORed with the always-set bit 31.
- R10: Capability (offset 0x00) reads NUM_PORTS-1 in bits 4:0, NUM_SLOTS-1 in bits 12:8, value 1 in bits 23:20, and bits 18 and 30 set; ports-implemented (0x0C) reads one bit per port; version (0x10) reads 0x00010000.
- R11: Link status (offset 0x28) reads 0x00000113 when drive_present[p] is high and 0 otherwise.
- R12: Writing link control (offset 0x2C) with bits 3:0 equal 0 while they hold 1 resets the port: status, mask, command-issue, active, error and control clear, task-file reads 0x7F and the signature is re-derived from drive_present; any other write just stores the value.
- R13: Base-address words (0x00, 0x04, 0x08, 0x0C), error (0x30) and active (0x34) store and return the written 32-bit value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational, 0 when not reading |
| drive_present | input | NUM_PORTS | Drive attached, one bit per port |
| port_evt | input | NUM_PORTS*32 | One-cycle interrupt-status set pulses, 32 bits per port |
| irq_out | output | 1 | Merged interrupt line |

## Verification
The interrupt path is tried with an event behind a closed mask, with an open mask but global enable off, with both open, and after the port source is cleared, which separates the masking, the merge into the pending vector and the global gate. Address decoding is tried at a mid port window, just past the last window and with a misaligned write, which tells a truncated port index from a correct range check. The register semantics are told apart by writing patterns that set forbidden mask bits, the running bits, zeros to command-issue, and by racing an event against a clear on the same status bit. Link-control writes go through the 1-to-0 detect transition and a 2-to-0 transition to show that only the first resets the port.

// File: rtl/hba_pkg.sv
// Shared constants for the host adapter register file.
// Assumes 32-bit aligned registers; offsets are byte offsets.
package hba_pkg;
    // Global region offsets (low 8 address bits)
    localparam logic [7:0] G_CAP   = 8'h00;
    localparam logic [7:0] G_CTRL  = 8'h04;
    localparam logic [7:0] G_ISTAT = 8'h08;
    localparam logic [7:0] G_PIMPL = 8'h0C;
    localparam logic [7:0] G_VER   = 8'h10;

    // Port window offsets (low 7 address bits)
    localparam logic [6:0] P_CLB   = 7'h00;
    localparam logic [6:0] P_CLBU  = 7'h04;
    localparam logic [6:0] P_FB    = 7'h08;
    localparam logic [6:0] P_FBU   = 7'h0C;
    localparam logic [6:0] P_IS    = 7'h10;
    localparam logic [6:0] P_IE    = 7'h14;
    localparam logic [6:0] P_CMD   = 7'h18;
    localparam logic [6:0] P_TFD   = 7'h20;
    localparam logic [6:0] P_SIG   = 7'h24;
    localparam logic [6:0] P_LSTS  = 7'h28;
    localparam logic [6:0] P_LCTL  = 7'h2C;
    localparam logic [6:0] P_LERR  = 7'h30;
    localparam logic [6:0] P_LACT  = 7'h34;
    localparam logic [6:0] P_CI    = 7'h38;

    // Command word bit positions
    localparam int CMD_ST  = 0;
    localparam int CMD_FRE = 4;
    localparam int CMD_FR  = 14;
    localparam int CMD_CR  = 15;

    localparam logic [31:0] CMD_RESET   = 32'h0000_0006;
    localparam logic [31:0] IE_KEEP     = 32'hFDC0_00FF;
    localparam logic [31:0] TFD_RESET   = 32'h0000_007F;
    localparam logic [31:0] SIG_DISK    = 32'h0000_0101;
    localparam logic [31:0] SIG_NONE    = 32'hFFFF_FFFF;
    localparam logic [31:0] LSTS_UP     = 32'h0000_0113;
    localparam logic [31:0] CAP_FLAGS   = 32'h4014_0000;
    localparam logic [31:0] VER_VAL     = 32'h0001_0000;
    localparam logic [31:0] CTRL_AE     = 32'h8000_0000;
    localparam logic [3:0]  DET_ARMED   = 4'h1;

    localparam int GLOBAL_SPAN = 256;
    localparam int WIN_BYTES   = 128;
endpackage

// File: rtl/hba_addr_decode.sv
// Address decoder: splits a byte address into global-region select,
// port-window select and port index. Assumes ADDR_W >= 8 and that the
// port region fits in the address space.
module hba_addr_decode #(
    parameter int NUM_PORTS = 4,
    parameter int ADDR_W    = 12,
    parameter int PIDX_W    = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_global,
    output logic              in_port,
    output logic [PIDX_W-1:0] port_idx
);
    import hba_pkg::*;
    localparam int PORT_END = GLOBAL_SPAN + NUM_PORTS * WIN_BYTES;

    logic [31:0]       addr32;
    logic [ADDR_W-1:0] rel;

    // Region classification and window index
    always_comb begin
        addr32    = 32'(addr);
        rel       = addr - ADDR_W'(GLOBAL_SPAN);
        in_global = addr32 < 32'(GLOBAL_SPAN);
        in_port   = !in_global && (addr32 < 32'(PORT_END));
        port_idx  = PIDX_W'(rel >> 7);
    end
endmodule

// File: rtl/hba_port_regs.sv
// One port's register window. Holds storage, W1C status, masked mask,
// OR-on-write issue vector, command running bits and the link-control
// triggered port reset. Assumes wr_en is already qualified by decode.
module hba_port_regs (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hba_rst,
    input  logic        wr_en,
    input  logic [6:0]  off,
    input  logic [31:0] wdata,
    input  logic        present,
    input  logic [31:0] evt_set,
    output logic [31:0] rdata,
    output logic [31:0] is_q,
    output logic [31:0] ie_q,
    output logic [31:0] ci_q,
    output logic [31:0] cmd_q,
    output logic        port_rst
);
    import hba_pkg::*;

    logic [31:0] clb_q, clbu_q, fb_q, fbu_q, lctl_q, lerr_q, lact_q, sig_q, tfd_q;
    logic [31:0] sig_init, is_clr, cmd_new;

    // Derived values used by the update process
    always_comb begin
        sig_init = present ? SIG_DISK : SIG_NONE;
        port_rst = wr_en && (off == P_LCTL) && (lctl_q[3:0] == DET_ARMED) && (wdata[3:0] == 4'h0);
        is_clr   = (wr_en && off == P_IS) ? wdata : 32'h0;
        cmd_new  = wdata & ~((32'h1 << CMD_CR) | (32'h1 << CMD_FR));
        cmd_new[CMD_CR] = wdata[CMD_ST];
        cmd_new[CMD_FR] = wdata[CMD_FRE];
    end

    // Register update: resets, event sets, and per-offset write semantics
    always_ff @(posedge clk) begin
        if (!rst_n || hba_rst) begin
            clb_q <= '0; clbu_q <= '0; fb_q <= '0; fbu_q <= '0;
            is_q <= '0; ie_q <= '0; cmd_q <= CMD_RESET; ci_q <= '0;
            lctl_q <= '0; lerr_q <= '0; lact_q <= '0;
            sig_q <= sig_init; tfd_q <= TFD_RESET;
        end else if (port_rst) begin
            is_q <= evt_set; ie_q <= '0; ci_q <= '0;
            lctl_q <= '0; lerr_q <= '0; lact_q <= '0;
            sig_q <= sig_init; tfd_q <= TFD_RESET;
        end else begin
            is_q <= (is_q & ~is_clr) | evt_set;
            if (wr_en) begin
                case (off)
                    P_CLB:  clb_q  <= wdata;
                    P_CLBU: clbu_q <= wdata;
                    P_FB:   fb_q   <= wdata;
                    P_FBU:  fbu_q  <= wdata;
                    P_IE:   ie_q   <= wdata & IE_KEEP;
                    P_CMD:  cmd_q  <= cmd_new;
                    P_LCTL: lctl_q <= wdata;
                    P_LERR: lerr_q <= wdata;
                    P_LACT: lact_q <= wdata;
                    P_CI:   ci_q   <= ci_q | wdata;
                    default: ;
                endcase
            end
        end
    end

    // Read multiplexer for this window
    always_comb begin
        case (off)
            P_CLB:  rdata = clb_q;
            P_CLBU: rdata = clbu_q;
            P_FB:   rdata = fb_q;
            P_FBU:  rdata = fbu_q;
            P_IS:   rdata = is_q;
            P_IE:   rdata = ie_q;
            P_CMD:  rdata = cmd_q;
            P_TFD:  rdata = tfd_q;
            P_SIG:  rdata = sig_q;
            P_LSTS: rdata = present ? LSTS_UP : 32'h0;
            P_LCTL: rdata = lctl_q;
            P_LERR: rdata = lerr_q;
            P_LACT: rdata = lact_q;
            P_CI:   rdata = ci_q;
            default: rdata = 32'h0;
        endcase
    end
endmodule

// File: rtl/hba_irq_merge.sv
// Folds each port's masked status into a registered pending vector and
// gates the merged line with the global enable. Assumes flat inputs.
module hba_irq_merge #(
    parameter int NUM_PORTS = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      hba_rst,
    input  logic [NUM_PORTS-1:0][31:0] is_v,
    input  logic [NUM_PORTS-1:0][31:0] ie_v,
    input  logic                      irq_en,
    output logic [NUM_PORTS-1:0]      pending_q,
    output logic                      irq
);
    logic [NUM_PORTS-1:0] masked;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_fold
        // Port p has an unmasked cause
        assign masked[p] = |(is_v[p] & ie_v[p]);
    end

    // Pending vector recomputed every cycle
    always_ff @(posedge clk) begin
        if (!rst_n || hba_rst) pending_q <= '0;
        else                   pending_q <= masked;
    end

    // Merged line gated by global enable
    assign irq = (|pending_q) && irq_en;
endmodule

// File: rtl/hba_regfile.sv
// Top of the host adapter register file: bus qualification, global
// registers, per-port windows and interrupt merge. Assumes accesses are
// single-cycle, reads combinational, NUM_PORTS between 1 and 30.
module hba_regfile #(
    parameter int NUM_PORTS = 4,
    parameter int NUM_SLOTS = 32,
    parameter int ADDR_W    = 12
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_valid,
    input  logic                   bus_write,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    input  logic [NUM_PORTS-1:0]   drive_present,
    input  logic [NUM_PORTS*32-1:0] port_evt,
    output logic                   irq_out
);
    import hba_pkg::*;
    localparam int PIDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
    localparam logic [31:0] CAP_VAL = CAP_FLAGS | 32'(NUM_PORTS - 1) | (32'(NUM_SLOTS - 1) << 8);
    localparam logic [31:0] PI_VAL  = 32'((64'd1 << NUM_PORTS) - 64'd1);

    logic                        in_global, in_port, wr_ok, hba_rst, ghc_ie_q;
    logic [PIDX_W-1:0]           port_idx;
    logic [NUM_PORTS-1:0]        pending_q, port_rst_v, wr_port;
    logic [NUM_PORTS-1:0]        st_v, cr_v, fre_v, fr_v;
    logic [NUM_PORTS-1:0][31:0]  rd_v, is_v, ie_v, ci_v, cmd_v;
    logic [31:0]                 glob_rd;

    hba_addr_decode #(.NUM_PORTS(NUM_PORTS), .ADDR_W(ADDR_W), .PIDX_W(PIDX_W)) u_dec (
        .addr(bus_addr), .in_global(in_global), .in_port(in_port), .port_idx(port_idx)
    );

    // Qualified write strobe and adapter reset trigger
    always_comb begin
        wr_ok   = bus_valid && bus_write && (bus_addr[1:0] == 2'b00);
        hba_rst = wr_ok && in_global && (bus_addr[7:0] == G_CTRL) && bus_wdata[0];
    end

    // Global interrupt-enable bit
    always_ff @(posedge clk) begin
        if (!rst_n || hba_rst)                                ghc_ie_q <= 1'b0;
        else if (wr_ok && in_global && bus_addr[7:0] == G_CTRL) ghc_ie_q <= bus_wdata[1];
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign wr_port[p] = wr_ok && in_port && (port_idx == PIDX_W'(p));
        hba_port_regs u_port (
            .clk(clk), .rst_n(rst_n), .hba_rst(hba_rst), .wr_en(wr_port[p]),
            .off(bus_addr[6:0]), .wdata(bus_wdata), .present(drive_present[p]),
            .evt_set(port_evt[p*32 +: 32]), .rdata(rd_v[p]), .is_q(is_v[p]),
            .ie_q(ie_v[p]), .ci_q(ci_v[p]), .cmd_q(cmd_v[p]), .port_rst(port_rst_v[p])
        );
        assign st_v[p]  = cmd_v[p][CMD_ST];
        assign cr_v[p]  = cmd_v[p][CMD_CR];
        assign fre_v[p] = cmd_v[p][CMD_FRE];
        assign fr_v[p]  = cmd_v[p][CMD_FR];
    end

    hba_irq_merge #(.NUM_PORTS(NUM_PORTS)) u_irq (
        .clk(clk), .rst_n(rst_n), .hba_rst(hba_rst), .is_v(is_v), .ie_v(ie_v),
        .irq_en(ghc_ie_q), .pending_q(pending_q), .irq(irq_out)
    );

    // Global region read mux
    always_comb begin
        case (bus_addr[7:0])
            G_CAP:   glob_rd = CAP_VAL;
            G_CTRL:  glob_rd = CTRL_AE | {30'h0, ghc_ie_q, 1'b0};
            G_ISTAT: glob_rd = 32'(pending_q);
            G_PIMPL: glob_rd = PI_VAL;
            G_VER:   glob_rd = VER_VAL;
            default: glob_rd = 32'h0;
        endcase
    end

    // Bus read data selection
    always_comb begin
        if (!bus_valid || bus_write) bus_rdata = 32'h0;
        else if (in_global)          bus_rdata = glob_rd;
        else if (in_port)            bus_rdata = rd_v[port_idx];
        else                         bus_rdata = 32'h0;
    end
endmodule

// File: rtl/hba_regfile_chk.sv
// Assertion checker bound to hba_regfile. Observes the interrupt line,
// the global enable, reset triggers and per-port state vectors.
module hba_regfile_chk #(
    parameter int NUM_PORTS = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      irq_out,
    input logic                      ghc_ie,
    input logic                      hba_rst,
    input logic [NUM_PORTS-1:0]      port_rst,
    input logic [NUM_PORTS*32-1:0]   port_evt,
    input logic [NUM_PORTS-1:0][31:0] is_v,
    input logic [NUM_PORTS-1:0][31:0] ci_v,
    input logic [NUM_PORTS-1:0]      st_v,
    input logic [NUM_PORTS-1:0]      cr_v,
    input logic [NUM_PORTS-1:0]      fre_v,
    input logic [NUM_PORTS-1:0]      fr_v
);
    // R4: the line never rises without the global enable
    a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ghc_ie);

    // R9: adapter reset drops the global enable
    a_r9_reset_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
        hba_rst |=> !ghc_ie);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        // R8: issue bits only fall through a reset
        a_r8_issue_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (!hba_rst && !port_rst[p]) |=> ((ci_v[p] & $past(ci_v[p])) == $past(ci_v[p])));

        // R5: a status bit only rises when an event requested it
        a_r5_status_rise_from_event: assert property (@(posedge clk) disable iff (!rst_n)
            !hba_rst |=> ((is_v[p] & ~$past(is_v[p]) & ~$past(port_evt[p*32 +: 32])) == 32'h0));

        // R7: running bits mirror their enables
        a_r7_list_running: assert property (@(posedge clk) disable iff (!rst_n)
            cr_v[p] == st_v[p]);
        a_r7_rx_running: assert property (@(posedge clk) disable iff (!rst_n)
            fr_v[p] == fre_v[p]);
    end
endmodule

bind hba_regfile hba_regfile_chk #(.NUM_PORTS(NUM_PORTS)) u_chk (
    .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .ghc_ie(ghc_ie_q), .hba_rst(hba_rst),
    .port_rst(port_rst_v), .port_evt(port_evt), .is_v(is_v), .ci_v(ci_v),
    .st_v(st_v), .cr_v(cr_v), .fre_v(fre_v), .fr_v(fr_v)
);

// File: tb/test_hba_regfile.sv
module test_hba_regfile;
    localparam int NP = 4;
    localparam int AW = 12;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_valid = 1'b0, bus_write = 1'b0;
    logic [AW-1:0]  bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NP-1:0]  drive_present = 4'b0101;
    logic [NP*32-1:0] port_evt = '0;
    logic           irq_out;
    int             n_tests = 0, n_fail = 0;
    logic [31:0]    rv;

    always #4 clk = ~clk;

    hba_regfile #(.NUM_PORTS(NP), .NUM_SLOTS(32), .ADDR_W(AW)) i_hba_regfile (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .drive_present(drive_present), .port_evt(port_evt), .irq_out(irq_out)
    );

    function automatic logic [AW-1:0] pa(input int p, input int off);
        return AW'(256 + p * 128 + off);
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_evt(input int p, input logic [31:0] bits);
        @(negedge clk);
        port_evt[p*32 +: 32] = bits;
        @(negedge clk);
        port_evt = '0;
    endtask

    task automatic t_reset;
        rd(12'h004, rv); check("R2 global control", rv, 32'h8000_0000);
        rd(pa(0, 'h18), rv); check("R2 command word", rv, 32'h0000_0006);
        rd(pa(0, 'h24), rv); check("R2 signature present", rv, 32'h0000_0101);
        rd(pa(1, 'h24), rv); check("R2 signature absent", rv, 32'hFFFF_FFFF);
        rd(pa(2, 'h20), rv); check("R2 task file", rv, 32'h0000_007F);
        rd(pa(3, 'h38), rv); check("R2 issue", rv, 32'h0);
        rd(12'h008, rv); check("R2 global status", rv, 32'h0);
        check("R2 irq low", {31'h0, irq_out}, 32'h0);
    endtask

    task automatic t_ident;
        rd(12'h000, rv); check("R10 capability", rv, 32'h4014_1F03);
        rd(12'h00C, rv); check("R10 ports implemented", rv, 32'h0000_000F);
        rd(12'h010, rv); check("R10 version", rv, 32'h0001_0000);
        rd(pa(0, 'h28), rv); check("R11 link status up", rv, 32'h0000_0113);
        rd(pa(1, 'h28), rv); check("R11 link status none", rv, 32'h0);
    endtask

    task automatic t_decode;
        wr(pa(2, 'h00), 32'hA5A5_0400);
        rd(pa(2, 'h00), rv); check("R1 port2 window", rv, 32'hA5A5_0400);
        rd(pa(3, 'h00), rv); check("R1 port3 untouched", rv, 32'h0);
        wr(12'h300, 32'h1234_5678);
        rd(12'h300, rv); check("R1 beyond ports reads 0", rv, 32'h0);
        rd(pa(0, 'h00), rv); check("R1 beyond ports no alias", rv, 32'h0);
        wr(pa(2, 'h02), 32'hDEAD_BEEF);
        rd(pa(2, 'h00), rv); check("R1 misaligned ignored", rv, 32'hA5A5_0400);
        wr(pa(1, 'h08), 32'h0000_0F00); rd(pa(1, 'h08), rv); check("R13 receive base", rv, 32'h0000_0F00);
        wr(pa(1, 'h0C), 32'h0000_0001); rd(pa(1, 'h0C), rv); check("R13 receive base hi", rv, 32'h1);
        wr(pa(1, 'h30), 32'h0F0F_0F0F); rd(pa(1, 'h30), rv); check("R13 error word", rv, 32'h0F0F_0F0F);
        wr(pa(1, 'h34), 32'h8000_0001); rd(pa(1, 'h34), rv); check("R13 active word", rv, 32'h8000_0001);
    endtask

    task automatic t_mask;
        wr(pa(1, 'h14), 32'hFFFF_FFFF);
        rd(pa(1, 'h14), rv); check("R6 mask filter", rv, 32'hFDC0_00FF);
        wr(pa(1, 'h14), 32'h0);
    endtask

    task automatic t_cmd;
        wr(pa(0, 'h18), 32'h0000_C010);
        rd(pa(0, 'h18), rv); check("R7 receive running from enable", rv, 32'h0000_4010);
        wr(pa(0, 'h18), 32'h0000_0001);
        rd(pa(0, 'h18), rv); check("R7 list running from start", rv, 32'h0000_8001);
        wr(pa(0, 'h18), 32'h0000_0006);
    endtask

    task automatic t_issue;
        wr(pa(3, 'h38), 32'h5);
        wr(pa(3, 'h38), 32'hA);
        rd(pa(3, 'h38), rv); check("R8 issue OR", rv, 32'hF);
        wr(pa(3, 'h38), 32'h0);
        rd(pa(3, 'h38), rv); check("R8 issue no clear", rv, 32'hF);
    endtask

    task automatic t_irq;
        pulse_evt(2, 32'h1);
        idle(2);
        rd(12'h008, rv); check("R3 masked cause not pending", rv, 32'h0);
        wr(pa(2, 'h14), 32'h1);
        idle(2);
        rd(12'h008, rv); check("R3 pending bit", rv, 32'h4);
        check("R4 irq off without enable", {31'h0, irq_out}, 32'h0);
        wr(12'h004, 32'h0000_0002);
        idle(1);
        check("R4 irq on", {31'h0, irq_out}, 32'h1);
        rd(12'h004, rv); check("R9 control value", rv, 32'h8000_0002);
        wr(12'h008, 32'h4);
        idle(2);
        rd(12'h008, rv); check("R3 global clear blocked", rv, 32'h4);
        wr(pa(2, 'h10), 32'h1);
        idle(2);
        rd(pa(2, 'h10), rv); check("R5 status cleared", rv, 32'h0);
        rd(12'h008, rv); check("R3 pending dropped", rv, 32'h0);
        check("R4 irq off after clear", {31'h0, irq_out}, 32'h0);
    endtask

    task automatic t_w1c;
        pulse_evt(3, 32'h3);
        rd(pa(3, 'h10), rv); check("R5 event sets", rv, 32'h3);
        wr(pa(3, 'h10), 32'h1);
        rd(pa(3, 'h10), rv); check("R5 write-one clears", rv, 32'h2);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = pa(3, 'h10); bus_wdata = 32'h2;
        port_evt[3*32 +: 32] = 32'h2;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0; port_evt = '0;
        rd(pa(3, 'h10), rv); check("R5 event wins over clear", rv, 32'h2);
    endtask

    task automatic t_lctl;
        wr(pa(0, 'h38), 32'h3);
        wr(pa(0, 'h2C), 32'h2);
        wr(pa(0, 'h2C), 32'h0);
        rd(pa(0, 'h38), rv); check("R12 no reset on 2 to 0", rv, 32'h3);
        wr(pa(0, 'h14), 32'h1);
        wr(pa(0, 'h2C), 32'h1);
        rd(pa(0, 'h2C), rv); check("R12 control stores", rv, 32'h1);
        wr(pa(0, 'h2C), 32'h0);
        rd(pa(0, 'h38), rv); check("R12 issue cleared", rv, 32'h0);
        rd(pa(0, 'h14), rv); check("R12 mask cleared", rv, 32'h0);
        rd(pa(0, 'h24), rv); check("R12 signature", rv, 32'h0000_0101);
        rd(pa(0, 'h20), rv); check("R12 task file", rv, 32'h0000_007F);
    endtask

    task automatic t_hba_reset;
        wr(12'h004, 32'hFFFF_FFFE);
        rd(12'h004, rv); check("R9 control low bits only", rv, 32'h8000_0002);
        wr(pa(1, 'h38), 32'h9);
        wr(pa(1, 'h18), 32'h11);
        wr(12'h004, 32'h0000_0003);
        rd(12'h004, rv); check("R9 reset control", rv, 32'h8000_0000);
        rd(pa(1, 'h38), rv); check("R9 reset issue", rv, 32'h0);
        rd(pa(1, 'h18), rv); check("R9 reset command", rv, 32'h0000_0006);
        rd(pa(2, 'h00), rv); check("R9 reset base", rv, 32'h0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_ident;
        t_decode;
        t_mask;
        t_cmd;
        t_issue;
        t_irq;
        t_w1c;
        t_lctl;
        t_hba_reset;
        idle(2);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule